// File: doc/BRIEF.md
# Single-Cycle Split-Bus Load/Store Core

This block is a compact processor core that finishes one instruction every clock cycle. Instructions arrive on their own 32-bit fetch port. Loads and stores go through a separate 32-bit data port, so the instruction space and the data space never share an address. Both memory models are external, and reads on both ports are combinational. The architectural state is a file of sixteen 32-bit general-purpose registers (r0 is an ordinary register), a program counter and four arithmetic flags.

The core runs eight instruction kinds, selected by the top four bits of the instruction word:
- 0: load a sign-extended immediate
- 1: load a word from memory
- 2: store a word to memory
- 3: add
- 4: subtract
- 5: jump through a register
- 6: jump through a register when a flag condition holds
- 7: branch relative to the PC

Field layout:
- destination register: bits [27:24]
- first source register: bits [23:20]
- second source register: bits [19:16]
- 16-bit immediate or offset: bits [15:0]

Opcodes 8 to 15 do nothing but advance the PC.

Top module: `mini_core`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high at a clock edge, the PC, all sixteen registers and all four flags return to zero. After release the first fetch address is 0, and every flag test reads the flags as clear.
- R2: `imem_addr` always shows the PC. An instruction that does not redirect control sets the PC to PC+4 at the next edge.
- R3: Opcode 0 writes the low 16 bits [15:0], sign-extended from bit 15, into the destination register [27:24].
- R4: Opcode 1 writes `dmem_rdata` into the destination register, read from address R[src A] + sign-extended [15:0].
- R5: Opcode 2 drives `dmem_addr` = R[src A] + sign-extended [15:0] and `dmem_wdata` = R[src B], with `dmem_we` high. `dmem_we` is low for every other instruction.
- R6: Opcode 3 writes R[A]+R[B] and opcode 4 writes R[A]-R[B] into the destination register, both modulo 2^32.
- R7: Add and subtract set the flags as follows:
  - Z: the result is zero.
  - N: result bit 31.
  - C: unsigned carry out on add; on subtract, R[A] >= R[B] unsigned (no borrow).
  - V: signed two's-complement overflow.
- R8: Loads, stores, jumps, branches and undefined opcodes leave all four flags unchanged.
- R9: Opcode 5 sets the next PC to R[src A].
- R10: Opcode 6 sets the next PC to R[src A] when the condition in bits [26:24] holds, and to PC+4 otherwise. The condition codes are:
  - 0: Z set
  - 1: Z clear
  - 2: C set
  - 3: C clear
  - 4: N set
  - 5: N clear
  - 6: V set
  - 7: always
- R11: Opcode 7 sets the next PC to its own address plus the sign-extended [15:0] times 4.
- R12: Opcodes 8 to 15 write no register, do not assert `dmem_we`, keep the flags and advance the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch address (current PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Data address for loads and stores |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |

## Verification
The bench goes after the arithmetic edges:
- 0x7FFFFFFF + 1 must raise V and N. A core that took V from the carry would miss it.
- 0xFFFFFFFF + 1 must give zero with C set.
- Subtracting equal values must leave C set, because C means no borrow. A core that inverted the borrow would flip the condition-2 and condition-3 jumps.
- 0 - 1 must leave C clear.
- 0x80000000 - 1 must raise V.

Every one of the eight jump conditions is probed after each of these cases, and again after loads, stores and jumps, to catch flags that are disturbed by non-arithmetic instructions. Other directed checks cover:
- immediate sign extension across bit 15;
- backward branches, so that a core adding the offset to PC+4 is caught;
- undefined opcodes, which must not write a register or strobe a store.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 16;
  localparam int RIDX = $clog2(NREG);
  localparam int IMMW = 16;

  // opcode values, field [31:28]
  localparam logic [3:0] OP_LDI = 4'd0;
  localparam logic [3:0] OP_LD  = 4'd1;
  localparam logic [3:0] OP_ST  = 4'd2;
  localparam logic [3:0] OP_ADD = 4'd3;
  localparam logic [3:0] OP_SUB = 4'd4;
  localparam logic [3:0] OP_JMP = 4'd5;
  localparam logic [3:0] OP_JC  = 4'd6;
  localparam logic [3:0] OP_BR  = 4'd7;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } flags_t;

  typedef struct packed {
    logic [XLEN-1:0] res;
    flags_t          fl;
  } alu_out_t;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] h);
    return {{(XLEN-IMMW){h[IMMW-1]}}, h};
  endfunction

  // add or subtract via an extended adder; carry out doubles as no-borrow
  function automatic alu_out_t addsub(input logic [XLEN-1:0] a,
                                      input logic [XLEN-1:0] b,
                                      input logic sub);
    alu_out_t o;
    logic [XLEN-1:0] bo;
    logic [XLEN:0]   sum;
    bo   = sub ? ~b : b;
    sum  = {1'b0, a} + {1'b0, bo} + {{XLEN{1'b0}}, sub};
    o.res  = sum[XLEN-1:0];
    o.fl.c = sum[XLEN];
    o.fl.z = (sum[XLEN-1:0] == '0);
    o.fl.n = sum[XLEN-1];
    o.fl.v = (a[XLEN-1] == bo[XLEN-1]) && (sum[XLEN-1] != a[XLEN-1]);
    return o;
  endfunction

  function automatic logic cond_met(input logic [2:0] sel, input flags_t f);
    logic r;
    case (sel)
      3'd0: r = f.z;
      3'd1: r = !f.z;
      3'd2: r = f.c;
      3'd3: r = !f.c;
      3'd4: r = f.n;
      3'd5: r = !f.n;
      3'd6: r = f.v;
      default: r = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
#(
  parameter int N = NREG,
  parameter int W = XLEN,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we && (waddr == AW'(g)))
        regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sub,
  output logic [XLEN-1:0] res,
  output flags_t          fl
);
  alu_out_t o;
  always_comb begin
    o   = addsub(a, b, sub);
    res = o.res;
    fl  = o.fl;
  end
endmodule

// File: rtl/mc_branch.sv
module mc_branch
  import mc_pkg::*;
(
  input  logic [3:0]      op,
  input  logic [2:0]      cond,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] jreg,
  input  logic [XLEN-1:0] off,
  input  flags_t          fl,
  output logic            redirect,
  output logic [XLEN-1:0] target
);
  always_comb begin
    redirect = (op == OP_JMP) || (op == OP_BR) ||
               ((op == OP_JC) && cond_met(cond, fl));
    target   = (op == OP_BR) ? pc + (off << 2) : jreg;
  end
endmodule

// File: rtl/mini_core.sv
module mini_core
  import mc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  logic [XLEN-1:0] pc_q;
  flags_t          flags_q;

  // decoded fields
  logic [3:0]      op;
  logic [RIDX-1:0] rd, ra, rb;
  logic [2:0]      cond;
  logic [XLEN-1:0] imm_x;
  assign op    = imem_rdata[31:28];
  assign rd    = imem_rdata[27:24];
  assign ra    = imem_rdata[23:20];
  assign rb    = imem_rdata[19:16];
  assign cond  = imem_rdata[26:24];
  assign imm_x = sext_imm(imem_rdata[15:0]);

  // named internal events
  logic            undef_op;
  logic            rf_we;
  logic            flag_we;
  logic            redirect;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] ra_val, rb_val, alu_res, rf_wdata;
  flags_t          alu_fl;

  assign undef_op = op[3];
  assign flag_we  = (op == OP_ADD) || (op == OP_SUB);
  assign rf_we    = (op == OP_LDI) || (op == OP_LD) || flag_we;

  mc_regfile #(.N(NREG), .W(XLEN)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rd), .wdata(rf_wdata),
    .raddr_a(ra), .raddr_b(rb), .rdata_a(ra_val), .rdata_b(rb_val)
  );

  mc_alu u_alu (
    .a(ra_val), .b(rb_val), .sub(op == OP_SUB), .res(alu_res), .fl(alu_fl)
  );

  mc_branch u_br (
    .op(op), .cond(cond), .pc(pc_q), .jreg(ra_val), .off(imm_x),
    .fl(flags_q), .redirect(redirect), .target(target)
  );

  always_comb begin
    case (op)
      OP_LDI:  rf_wdata = imm_x;
      OP_LD:   rf_wdata = dmem_rdata;
      default: rf_wdata = alu_res;
    endcase
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = ra_val + imm_x;
  assign dmem_wdata = rb_val;
  assign dmem_we    = (op == OP_ST) && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      flags_q <= '0;
    end else begin
      pc_q <= redirect ? target : pc_q + 32'd4;
      if (flag_we)
        flags_q <= alu_fl;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && flags_q == '0));

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> pc_q == $past(pc_q) + 32'd4);

  // R8
  flags_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(flags_q));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> (flags_q.z == ($past(alu_res) == '0)));

  // R10
  always_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_JC && cond == 3'd7) |-> redirect);

  // R12
  undef_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    undef_op |-> (!rf_we && !dmem_we && !redirect));
endmodule

// File: tb/mini_core_test.sv
`timescale 1ns/1ps
module mini_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] mem [64];
  assign dmem_rdata = mem[dmem_addr[7:2]];

  mini_core uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  always #10 clk = ~clk;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  // reference state
  logic [31:0] m_r [16];
  logic        m_c, m_z, m_n, m_v;
  logic [31:0] m_pc;

  function automatic logic [31:0] sx(input logic [15:0] h);
    return {{16{h[15]}}, h};
  endfunction

  function automatic logic [31:0] enc(input int op, input int rd, input int ra,
                                      input int rb, input logic [15:0] imm);
    return {op[3:0], rd[3:0], ra[3:0], rb[3:0], imm};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3, 4'd4: return "R6";
      4'd5: return "R9";
      4'd6: return "R10";
      4'd7: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // signed-range and compare based flag model
  task automatic ref_arith(input logic [31:0] a, input logic [31:0] b,
                           input bit sub, output logic [31:0] res);
    longint s;
    if (sub) begin
      res = a - b;
      s   = longint'($signed(a)) - longint'($signed(b));
      m_c = (a >= b);
    end else begin
      res = a + b;
      s   = longint'($signed(a)) + longint'($signed(b));
      m_c = (res < a);
    end
    m_v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    m_z = (res == 32'd0);
    m_n = res[31];
  endtask

  function automatic bit cond_ok(input logic [2:0] c);
    case (c)
      3'd0: return m_z;
      3'd1: return !m_z;
      3'd2: return m_c;
      3'd3: return !m_c;
      3'd4: return m_n;
      3'd5: return !m_n;
      3'd6: return m_v;
      default: return 1'b1;
    endcase
  endfunction

  task automatic model_step(input logic [31:0] ins);
    logic [3:0]  op;
    logic [31:0] a, b, ea, nx, res;
    op = ins[31:28];
    a  = m_r[ins[23:20]];
    b  = m_r[ins[19:16]];
    ea = a + sx(ins[15:0]);
    nx = m_pc + 32'd4;
    case (op)
      4'd0: m_r[ins[27:24]] = sx(ins[15:0]);
      4'd1: m_r[ins[27:24]] = mem[ea[7:2]];
      4'd3: begin ref_arith(a, b, 1'b0, res); m_r[ins[27:24]] = res; end
      4'd4: begin ref_arith(a, b, 1'b1, res); m_r[ins[27:24]] = res; end
      4'd5: nx = a;
      4'd6: if (cond_ok(ins[26:24])) nx = a;
      4'd7: nx = m_pc + {sx(ins[15:0]), 2'b00};
      default: ;
    endcase
    m_pc = nx;
  endtask

  task automatic issue(input logic [31:0] ins, input string tag);
    logic [31:0] ea, wd;
    bit          exp_we;
    imem_rdata = ins;
    #1;
    exp_we = (ins[31:28] == 4'd2);
    ea     = m_r[ins[23:20]] + sx(ins[15:0]);
    wd     = m_r[ins[19:16]];
    chk(dmem_we === exp_we, tag, {31'd0, dmem_we}, {31'd0, exp_we});
    if (exp_we) begin
      chk(dmem_addr === ea, tag, dmem_addr, ea);
      chk(dmem_wdata === wd, tag, dmem_wdata, wd);
    end
    model_step(ins);
    @(posedge clk);
    if (exp_we) mem[ea[7:2]] = wd;
    @(negedge clk);
    chk(imem_addr === m_pc, tag, imem_addr, m_pc);
  endtask

  task automatic peek(input int r, input string tag);
    issue(enc(2, 0, 0, r, 16'h0000), tag);
  endtask

  task automatic probe(input string tag);
    for (int c = 0; c < 8; c++) issue(enc(6, c, 15, 0, 16'h0), tag);
  endtask

  task automatic arith_case(input int ia, input int ib, input bit sub);
    issue(enc(0, 0, 0, 0, 16'h0), "R3");
    issue(enc(1, 3, 0, 0, 16'(ia * 4)), "R4");
    issue(enc(1, 4, 0, 0, 16'(ib * 4)), "R4");
    peek(3, "R4");
    issue(enc(sub ? 4 : 3, 5, 3, 4, 16'h0), "R6");
    peek(5, "R6");
    probe("R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    imem_rdata = 32'hF000_0000;
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    mem[1] = 32'h7FFF_FFFF;
    mem[2] = 32'h0000_0001;
    mem[3] = 32'hFFFF_FFFF;
    mem[4] = 32'h8000_0000;
    mem[5] = 32'h0000_0000;
    for (int i = 0; i < 16; i++) m_r[i] = 32'd0;
    {m_c, m_z, m_n, m_v} = 4'b0000;
    m_pc = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(imem_addr === 32'd0, "R1", imem_addr, 32'd0);
    for (int r = 0; r < 16; r++) peek(r, "R1");
    probe("R1");

    // R3 sign extension on both sides of bit 15
    issue(enc(0, 1, 0, 0, 16'h8000), "R3");
    peek(1, "R3");
    issue(enc(0, 2, 0, 0, 16'h7FFF), "R3");
    peek(2, "R3");

    // R7 flag corners
    arith_case(1, 2, 1'b0);
    arith_case(3, 2, 1'b0);
    arith_case(2, 2, 1'b1);
    arith_case(5, 2, 1'b1);
    arith_case(4, 2, 1'b1);

    // R8 non-arithmetic instructions keep flags
    arith_case(1, 2, 1'b0);
    issue(enc(0, 6, 0, 0, 16'h0400), "R8");
    issue(enc(1, 7, 0, 0, 16'h0010), "R8");
    issue(enc(2, 0, 0, 6, 16'h0020), "R8");
    issue(enc(5, 0, 6, 0, 16'h0), "R9");
    issue(enc(7, 0, 0, 0, 16'h0002), "R11");
    issue(enc(8, 9, 0, 0, 16'h0), "R12");
    probe("R8");

    // R11 backward and forward branches
    issue(enc(7, 0, 0, 0, 16'hFFFD), "R11");
    issue(enc(7, 0, 0, 0, 16'h0005), "R11");

    // R12 undefined opcodes
    issue(enc(0, 9, 0, 0, 16'h1234), "R3");
    issue(32'hF9A5_1234, "R12");
    issue(32'h9912_ABCD, "R12");
    peek(9, "R12");
    probe("R12");

    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ins;
      ins = $urandom;
      if (($urandom % 8) != 0) ins[31] = 1'b0;
      issue(ins, tag_of(ins[31:28]));
    end
    for (int r = 0; r < 16; r++) peek(r, "R6");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule